// File: doc/BRIEF.md
# Serial EEPROM Read Responder

This block behaves as the slave side of a bit-banged three-wire serial EEPROM link that holds up to 64 words of 16 bits. A host drives a select line, a serial clock and a data line. The block sends data back on one output. All four link signals are sampled in the block's own clock domain. A transition on a link line takes effect on the first system clock edge at which the new level is seen.

After select rises, the block gathers command bits on serial-clock rising edges, least significant bit first. A command is nine bits long: a start bit, a two-bit operation and a six-bit word address. When a read command is complete, the block returns the addressed word over the next sixteen serial-clock rises, least significant bit first, and then goes idle. Any other complete command is dropped, and the block waits for a new one. The word store is loaded through a parallel write port. Only the first `WORDS` addresses are populated, and every other address reads as all ones.

Top module: `mw_eeprom_rd`

## Requirements
- R1: After reset `dout_o` is 1 and the block is idle. While select stays low, serial clock activity leaves `dout_o` at 1.
- R2: Any select transition, rising or falling, sets `dout_o` to 1 on the clock edge that detects it, and discards any partly collected command.
- R3: Only serial-clock rising edges advance the block. While the serial clock is held high or falls, and while data-in changes with no rising edge, `dout_o` keeps its value.
- R4: Command bits are stored least significant bit first. The first bit is cmd[0], the start bit. cmd[2:1] is the operation, and cmd[8:3] is the address, sent address bit 0 first. Read is cmd[2:0] = 3'b011, so on the wire it is 1, 1, 0. `dout_o` stays 1 while command bits are collected.
- R5: A nine-bit command whose start bit is 0 never starts a read. Further serial clocks leave `dout_o` at 1 until select toggles.
- R6: A complete command whose start bit is 1 but whose operation is not read is dropped. The block keeps waiting, and a read command sent next under the same select is served.
- R7: After a read command, each of the next 16 serial-clock rises drives `dout_o` with the next bit of the addressed word, bit 0 first. The new bit appears on the clock edge that detects the rise and is held until the next rise.
- R8: A read of an address at or above `WORDS` returns 1 for all 16 bits.
- R9: After the 16th data bit the block goes idle. Further serial clocks leave `dout_o` at the last bit sent until select rises again.
- R10: A write-port strobe with an address below `WORDS` replaces that word. A strobe with a higher address has no effect.
- R11: Dropping select during a data read aborts the read. `dout_o` goes to 1 and stays there under further serial clocks.
- R12: When select rise and a serial-clock rise are detected in the same cycle, that clock rise captures the first command bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all link lines are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Link select, active high |
| sck_i | input | 1 | Link serial clock |
| din_i | input | 1 | Link data from host |
| wr_en_i | input | 1 | Word store write strobe |
| wr_addr_i | input | ADDR_W | Word store write address |
| wr_data_i | input | DATA_W | Word store write data |
| dout_o | output | 1 | Link data to host |

## Verification
A wrong bit count or a misdecoded opcode shows at once as a data stream that starts one serial clock early or late, or never starts. The next serial-clock rise after the command then gives a wrong bit on `dout_o`. A stale state after a select edge shows in the cycle right after that edge, because `dout_o` must be 1 there. A bad end-of-word count shows on the 17th rise, when `dout_o` either moves or should not. Every serial-clock rise is therefore compared against a queued expected bit, so any such error surfaces within one link bit.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2
    } mw_state_e;

    // start bit in bit 0, operation {0,1} in bits 2:1
    localparam logic [2:0] RD_OPCODE = 3'b011;

endpackage

// File: rtl/mw_edge_det.sv
module mw_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= prev_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise_o[g] =  sig_i[g] & ~prev_q[g];
        assign fall_o[g] = ~sig_i[g] &  prev_q[g];
    end

endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
    parameter int WORDS  = 48,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_ok_o,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(WORDS);

    initial begin
        assert (WORDS <= (1 << ADDR_W))
        else $error("WORDS exceeds address space");
    end

    if (WORDS > 0) begin : g_mem
        logic [DATA_W-1:0] mem_q [WORDS];
        logic              wr_ok;

        assign wr_ok   = wr_en_i && ({1'b0, wr_addr_i} < LIMIT);
        assign rd_ok_o = {1'b0, rd_addr_i} < LIMIT;
        assign rd_data_o = rd_ok_o ? mem_q[rd_addr_i] : '1;

        always_ff @(posedge clk) begin
            if (wr_ok) mem_q[wr_addr_i] <= wr_data_i;
        end
    end else begin : g_empty
        assign rd_ok_o   = 1'b0;
        assign rd_data_o = '1;
    end

endmodule

// File: rtl/mw_eeprom_rd.sv
module mw_eeprom_rd #(
    parameter int WORDS  = 48,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              sck_i,
    input  logic              din_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              dout_o
);
    import mw_pkg::*;

    localparam int CMD_W = 3 + ADDR_W;
    localparam int CNT_W = $clog2(CMD_W + 1);
    localparam int POS_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(DATA_W - 1);
    localparam logic [POS_W-1:0] POS_ONE  = POS_W'(1);

    typedef struct packed {
        mw_state_e          st;
        logic [CMD_W-1:0]   cmd;
        logic [CNT_W-1:0]   cnt;
        logic [POS_W-1:0]   pos;
        logic               dout;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0]        rise, fall;
    logic              sel_rise, sel_fall, sck_rise;
    logic              word_ok;
    logic [DATA_W-1:0] word_bits;

    mw_edge_det #(.N(2)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  ({sck_i, sel_i}),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign sel_rise = rise[0];
    assign sel_fall = fall[0];
    assign sck_rise = rise[1];

    mw_word_store #(.WORDS(WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (r_q.cmd[CMD_W-1:3]),
        .rd_ok_o   (word_ok),
        .rd_data_o (word_bits)
    );

    always_comb begin
        r_d = r_q;
        // select edges are handled first; a clock rise in the same cycle then applies
        if (sel_rise || sel_fall) begin
            r_d.cnt  = '0;
            r_d.cmd  = '0;
            r_d.pos  = '0;
            r_d.dout = 1'b1;
            r_d.st   = sel_rise ? ST_CMD : ST_IDLE;
        end
        if (sck_rise) begin
            unique case (r_d.st)
                ST_CMD: begin
                    if (r_d.cnt != CNT_FULL) begin
                        r_d.cmd[r_d.cnt] = din_i;
                        r_d.cnt          = r_d.cnt + CNT_ONE;
                        if (r_d.cnt == CNT_FULL && r_d.cmd[0]) begin
                            r_d.cnt = '0;
                            if (r_d.cmd[2:0] == RD_OPCODE) begin
                                r_d.st  = ST_DATA;
                                r_d.pos = '0;
                            end else begin
                                r_d.cmd = '0;
                            end
                        end
                    end
                end
                ST_DATA: begin
                    r_d.dout = word_ok ? word_bits[r_d.pos] : 1'b1;
                    if (r_d.pos == POS_LAST) begin
                        r_d.st  = ST_IDLE;
                        r_d.pos = '0;
                    end else begin
                        r_d.pos = r_d.pos + POS_ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st   <= ST_IDLE;
            r_q.cmd  <= '0;
            r_q.cnt  <= '0;
            r_q.pos  <= '0;
            r_q.dout <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout_o = r_q.dout;

    // R1: idle persists until select rises
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_IDLE && !sel_rise) |=> (r_q.st == ST_IDLE));

    // R2: a select edge forces the output high
    p_sel_edge_high_r2: assert property (@(posedge clk) disable iff (rst)
        (sel_rise || sel_fall) |=> dout_o);

    // R3: without a clock rise or select edge the output holds
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!sck_rise && !sel_rise && !sel_fall) |=> $stable(dout_o));

    // R5: bit count never passes the command length
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        r_q.cnt <= CNT_FULL);

    // R8: an unpopulated address yields ones
    p_oob_ones_r8: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_DATA && sck_rise && !sel_rise && !sel_fall && !word_ok) |=> dout_o);

    // R9: the last data bit returns the block to idle
    p_word_end_r9: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_DATA && sck_rise && !sel_rise && !sel_fall && r_q.pos == POS_LAST)
        |=> (r_q.st == ST_IDLE));

endmodule

// File: tb/mw_eeprom_rd_tb.sv
module mw_eeprom_rd_tb;

    localparam int WORDS  = 48;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sel_i = 1'b0, sck_i = 1'b0, din_i = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [ADDR_W-1:0] wr_addr_i = '0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic              dout_o;

    always #2.5 clk = ~clk;

    mw_eeprom_rd #(.WORDS(WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (.*);

    typedef struct {
        logic  val;
        string req;
    } exp_t;

    exp_t              exp_q[$];
    event              bit_ev;
    int                n_vec  = 0;
    int                n_fail = 0;
    logic [DATA_W-1:0] model [1 << ADDR_W];

    task automatic check(input string req, input logic got, input logic exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: dout_o=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // monitor: compares each produced bit against the scoreboard
    initial begin
        forever begin
            @(bit_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, dout_o, e.val);
            end
        end
    end

    function automatic logic [DATA_W-1:0] word_at(input int a);
        return (a < WORDS) ? model[a] : '1;
    endfunction

    task automatic expect_now(input logic v, input string req);
        exp_q.push_back('{v, req});
        -> bit_ev;
        #0;
    endtask

    task automatic sel_set(input logic v);
        @(negedge clk); sel_i = v;
        @(negedge clk);
    endtask

    // one serial clock rise; hold extends the high phase with data-in toggling
    task automatic pulse(input logic d, input logic v, input string req, input int hold);
        @(negedge clk); din_i = d; sck_i = 1'b1;
        @(negedge clk); expect_now(v, req);
        for (int h = 0; h < hold; h++) begin
            din_i = ~din_i;
            @(negedge clk); expect_now(v, "R3");
        end
        sck_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_cmd(input logic [2:0] op, input int addr, input string req);
        logic [8:0] c;
        c = {6'(addr), op};
        for (int i = 0; i < 9; i++) pulse(c[i], 1'b1, req, 0);
    endtask

    task automatic data_bits(input int addr, input int first, input int last,
                             input string req, input int hold_at);
        logic [DATA_W-1:0] w;
        w = word_at(addr);
        for (int i = first; i <= last; i++)
            pulse(1'b0, w[i], req, (i == hold_at) ? 4 : 0);
    endtask

    task automatic read_word(input int addr, input string req);
        sel_set(1'b1);
        send_cmd(3'b011, addr, "R4");
        data_bits(addr, 0, DATA_W - 1, req, -1);
    endtask

    task automatic wr(input int a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = ADDR_W'(a); wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
        if (a < WORDS) model[a] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < (1 << ADDR_W); a++) model[a] = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", dout_o, 1'b1);

        // R1: clocks with select low do nothing
        for (int i = 0; i < 12; i++) pulse(i[0], 1'b1, "R1", 0);

        // R10: preload, including writes above WORDS that must be ignored
        for (int a = 0; a < (1 << ADDR_W); a++)
            wr(a, 16'(16'h3C5A ^ (a * 16'h0B07)));

        // R7 + R9: read, then extra clocks hold the final bit
        read_word(5, "R7");
        pulse(1'b1, word_at(5)[DATA_W-1], "R9", 0);
        pulse(1'b0, word_at(5)[DATA_W-1], "R9", 0);
        sel_set(1'b0);
        read_word(0, "R7");
        sel_set(1'b0);
        read_word(WORDS - 1, "R7");
        sel_set(1'b0);

        // R8: addresses above the populated range
        read_word(WORDS, "R8");
        sel_set(1'b0);
        read_word(63, "R8");
        sel_set(1'b0);
        read_word(40, "R10");
        sel_set(1'b0);

        // R3: long high phase with data-in toggling mid-read
        sel_set(1'b1);
        send_cmd(3'b011, 9, "R4");
        data_bits(9, 0, DATA_W - 1, "R3", 4);
        sel_set(1'b0);

        // R5: zero start bit never reads
        sel_set(1'b1);
        send_cmd(3'b010, 3, "R5");
        for (int i = 0; i < 20; i++) pulse(1'b0, 1'b1, "R5", 0);
        sel_set(1'b0);
        read_word(3, "R5");
        sel_set(1'b0);

        // R6: non-read operation then a read under the same select
        sel_set(1'b1);
        send_cmd(3'b101, 12, "R6");
        send_cmd(3'b011, 12, "R6");
        data_bits(12, 0, DATA_W - 1, "R6", -1);
        sel_set(1'b0);

        // R11: abort mid-read
        sel_set(1'b1);
        send_cmd(3'b011, 20, "R4");
        data_bits(20, 0, 4, "R11", -1);
        sel_set(1'b0);
        check("R11", dout_o, 1'b1);
        for (int i = 0; i < 4; i++) pulse(1'b0, 1'b1, "R11", 0);

        // R10 + R2: rewrite a word whose top bit is 0, then a select fall lifts the output
        wr(7, 16'h1234);
        read_word(7, "R10");
        check("R2", dout_o, 1'b0);
        sel_set(1'b0);
        check("R2", dout_o, 1'b1);

        // R2: select rise mid-command restarts collection
        sel_set(1'b1);
        for (int i = 0; i < 5; i++) pulse(1'b1, 1'b1, "R2", 0);
        sel_set(1'b0);
        sel_set(1'b1);
        send_cmd(3'b011, 30, "R2");
        data_bits(30, 0, DATA_W - 1, "R2", -1);
        sel_set(1'b0);

        // R12: select and clock rise seen together; that rise is the start bit
        @(negedge clk); sel_i = 1'b1; din_i = 1'b1; sck_i = 1'b1;
        @(negedge clk); expect_now(1'b1, "R12");
        sck_i = 1'b0;
        @(negedge clk);
        begin
            logic [8:0] c;
            c = {6'd33, 3'b011};
            for (int i = 1; i < 9; i++) pulse(c[i], 1'b1, "R12", 0);
        end
        data_bits(33, 0, DATA_W - 1, "R12", -1);
        sel_set(1'b0);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule